// File: doc/BRIEF.md
# Adaptive-Step Delta Encoder

This block turns a stream of 8-bit unsigned audio samples into one coded bit per bit period. It keeps an 8-bit reference level that tracks the input. Every bit period it decides whether the reference lies below the current sample and shifts that decision into a three-bit history. Each output bit is a decision taken a fixed number of bit periods earlier, so eight input bits become one line bit.

The step the reference moves by adapts to the signal. A run of three equal decisions means the reference is lagging a steep slope. The step then grows by a fixed increment, up to a ceiling. Any mixed history drops the step back to one. The new reference is held in a register and used by the comparator in the next bit period. A matching decoder can rebuild the same level from the bit stream alone.

An internal divider makes the bit-period strobe from the system clock. The clock is assumed to run at 1024 times the fastest line rate, which gives line rates in the ratio 4:2:1 (64, 32 and 16 kbit/s). The strobe is also driven out, so a downstream serializer knows when a new bit is on the line.

Top module: `cvsd_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the history is cleared, the reference is set to 128, the step is set to 1, and both `bit_out` and `bit_stb` are 0.
- R2: `bit_stb` is a one-cycle pulse that repeats every BASE_DIV clocks when `rate_sel` is 0, every 2*BASE_DIV clocks when it is 1, and every 4*BASE_DIV clocks when it is 2 or 3.
- R3: In a cycle where `bit_stb` is high, the decision is 0 when the stored reference is strictly below `pcm_in`, and 1 otherwise.
- R4: Each strobe shifts the decision into a three-bit history. `bit_out` is the oldest bit of that history, which is the decision from two strobes earlier. `bit_out` changes only on the clock edge that ends a strobe cycle.
- R5: When the history after the shift is all zeros or all ones, the step grows by STEP_INC and is capped at STEP_MAX.
- R6: When the history after the shift is mixed, the step returns to 1.
- R7: A decision of 0 raises the reference by the new step. A decision of 1 lowers it by the new step.
- R8: The reference saturates at 0 and at 255 and never wraps.
- R9: The reference and the step change only on the edge that ends a strobe cycle. The comparator always uses the value stored at the previous strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 1024 times the fastest line rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Line-rate select: 0 fastest, 1 half, 2 or 3 quarter |
| pcm_in | input | 8 | Unsigned audio sample, sampled in the strobe cycle |
| bit_stb | output | 1 | One-cycle pulse marking the cycle in which a bit is taken |
| bit_out | output | 1 | Coded serial bit |

## Verification
The hardest states to reach from the ports are the saturation corners. These are a reference pinned at 0 or 255, and a step held at its ceiling, and only the one-bit output shows them. The bench reaches them by holding the input at full scale or at zero for dozens of bit periods, so that runs push the step to STEP_MAX and the reference into the rail. It then moves the input by one code. A reference that wrapped instead of clamping would give a different bit sequence, and a bit-accurate model in the bench compares every output bit. A short table of hand-worked bits checks the run and mixed-history step rules before the long sequences.

// File: rtl/cvsd_pkg.sv
// Package: shared widths, constants and the rate-select encoding for the
// adaptive-step delta encoder. Assumes 8-bit unsigned samples.
package cvsd_pkg;
    localparam int unsigned LVL_W = 8;
    typedef logic [LVL_W-1:0] level_t;
    localparam level_t LVL_MID = 8'd128;
    localparam level_t LVL_TOP = 8'd255;

    // Line-rate select: divide factor is BASE_DIV times 1, 2 or 4
    typedef enum logic [1:0] {
        RATE_X1  = 2'd0,
        RATE_X2  = 2'd1,
        RATE_X4  = 2'd2,
        RATE_X4B = 2'd3
    } rate_e;
endpackage

// File: rtl/cvsd_rate_gen.sv
// Bit-period strobe generator. Divides the system clock by BASE_DIV, 2*BASE_DIV
// or 4*BASE_DIV depending on rate_sel_i and emits a one-cycle pulse per period.
// Assumes BASE_DIV >= 2. A rate change takes effect at the next counter wrap or
// immediately if the counter already exceeds the new limit.
module cvsd_rate_gen
    import cvsd_pkg::*;
#(
    parameter int unsigned BASE_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel_i,
    output logic       stb_o
);
    localparam int unsigned MAX_DIV = 4 * BASE_DIV;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             stb_q;

    // Terminal count for the selected rate
    always_comb begin
        case (rate_e'(rate_sel_i))
            RATE_X1: limit = CNT_W'(BASE_DIV - 1);
            RATE_X2: limit = CNT_W'(2 * BASE_DIV - 1);
            default: limit = CNT_W'(MAX_DIV - 1);
        endcase
    end

    // Free-running divider and strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            stb_q <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            stb_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            stb_q <= 1'b0;
        end
    end

    assign stb_o = stb_q;

    // R2: the strobe never lasts longer than one cycle
    p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
    // R2: the strobe rises only as the divider restarts
    p_stb_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_q) |-> (cnt_q == '0));
endmodule

// File: rtl/cvsd_history.sv
// Decision history: a HIST_W-bit serial-in shift register that takes one
// decision per strobe. Reports a run (all bits equal after the shift in the
// current strobe cycle) and drives the oldest bit as the coded output.
module cvsd_history #(
    parameter int unsigned HIST_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic dec_i,
    output logic run_o,
    output logic bit_o
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nx;

    // Next history including the decision made in this cycle
    assign hist_nx = {hist_q[HIST_W-2:0], dec_i};
    // Slope overload: every remembered decision points the same way
    assign run_o   = (&hist_nx) | ~(|hist_nx);

    // Shift register advancing once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (stb_i) begin
            hist_q <= hist_nx;
        end
    end

    assign bit_o = hist_q[HIST_W-1];

    // R4: older bits move up by one place on each strobe
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
    // R4: the newest bit is the decision presented in the strobe cycle
    p_hist_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (hist_q[0] == $past(dec_i)));
    // R4: no movement between strobes
    p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(hist_q));
endmodule

// File: rtl/cvsd_level_sel.sv
// Level select: adapts the step from the run flag and moves the stored
// reference by that step in the direction of the latest decision. The stored
// reference is the one-bit-period delay seen by the comparator. Assumes
// 1 <= STEP_INC and STEP_MAX <= 255.
module cvsd_level_sel
    import cvsd_pkg::*;
#(
    parameter int unsigned STEP_INC = 4,
    parameter int unsigned STEP_MAX = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stb_i,
    input  logic   dec_i,
    input  logic   run_i,
    output level_t ref_o
);
    localparam int unsigned STEP_W = $clog2(STEP_MAX + 1);

    level_t            ref_q;
    level_t            ref_nx;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nx;
    logic [8:0]        step_sum;
    logic [8:0]        ref_up;

    // Step adaptation: grow and clamp during a run, else minimum step
    always_comb begin
        step_sum = 9'(step_q) + 9'(STEP_INC);
        if (!run_i) begin
            step_nx = STEP_W'(1);
        end else if (step_sum > 9'(STEP_MAX)) begin
            step_nx = STEP_W'(STEP_MAX);
        end else begin
            step_nx = step_sum[STEP_W-1:0];
        end
    end

    // Reference update with clamping at both rails
    always_comb begin
        ref_up = {1'b0, ref_q} + 9'(step_nx);
        if (dec_i) begin
            ref_nx = (9'(step_nx) > {1'b0, ref_q}) ? '0 : ref_q - 8'(step_nx);
        end else begin
            ref_nx = (ref_up > {1'b0, LVL_TOP}) ? LVL_TOP : ref_up[7:0];
        end
    end

    // Reference and step registers, loaded once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= LVL_MID;
            step_q <= STEP_W'(1);
        end else if (stb_i) begin
            ref_q  <= ref_nx;
            step_q <= step_nx;
        end
    end

    assign ref_o = ref_q;

    // R5: the step stays between one and its ceiling
    p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q >= STEP_W'(1)) && (step_q <= STEP_W'(STEP_MAX)));
    // R5: a run with room below the ceiling grows the step by the increment
    p_step_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && run_i && (9'(step_q) + 9'(STEP_INC) <= 9'(STEP_MAX)))
        |=> (9'(step_q) == 9'($past(step_q)) + 9'(STEP_INC)));
    // R6: mixed history brings the step back to one
    p_step_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !run_i) |=> (step_q == STEP_W'(1)));
    // R7: decision 0 raises the reference unless already at the top rail
    p_ref_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !dec_i && (ref_q != LVL_TOP)) |=> (ref_q > $past(ref_q)));
    // R7: decision 1 lowers the reference unless already at zero
    p_ref_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && dec_i && (ref_q != '0)) |=> (ref_q < $past(ref_q)));
    // R8: no wrap past a rail
    p_ref_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !dec_i) |=> (ref_q >= $past(ref_q)));
    // R9: reference and step hold between strobes
    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(ref_q) && $stable(step_q)));
endmodule

// File: rtl/cvsd_encoder.sv
// Top of the adaptive-step delta encoder. Compares each sample with the stored
// reference once per bit period, records the decision in a short history,
// adapts the step and updates the reference. Assumes pcm_in is stable in the
// cycle where bit_stb is high.
module cvsd_encoder
    import cvsd_pkg::*;
#(
    parameter int unsigned BASE_DIV = 1024,
    parameter int unsigned STEP_INC = 4,
    parameter int unsigned STEP_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic [7:0] pcm_in,
    output logic       bit_stb,
    output logic       bit_out
);
    logic   stb;
    logic   dec;
    logic   run;
    level_t ref_lvl;

    cvsd_rate_gen #(
        .BASE_DIV (BASE_DIV)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel),
        .stb_o      (stb)
    );

    // Comparator: 0 when the reference lies below the sample
    assign dec = (ref_lvl < pcm_in) ? 1'b0 : 1'b1;

    cvsd_history #(
        .HIST_W (3)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (stb),
        .dec_i (dec),
        .run_o (run),
        .bit_o (bit_out)
    );

    cvsd_level_sel #(
        .STEP_INC (STEP_INC),
        .STEP_MAX (STEP_MAX)
    ) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (stb),
        .dec_i (dec),
        .run_i (run),
        .ref_o (ref_lvl)
    );

    assign bit_stb = stb;

    // R4: the coded bit moves only on the edge closing a strobe cycle
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(bit_out));
endmodule

// File: tb/cvsd_encoder_tb.sv
module cvsd_encoder_tb_top;
    localparam int DIV  = 4;
    localparam int INC  = 4;
    localparam int SMAX = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [7:0] pcm_in = 8'd0;
    logic       bit_stb;
    logic       bit_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state, built from the requirements
    int       m_ref;
    int       m_step;
    logic [2:0] m_hist;

    // table: {sample, expected bit} worked out from reset state
    localparam logic [8:0] VEC [15] = '{
        {8'd200, 1'b0}, {8'd200, 1'b0}, {8'd200, 1'b0}, {8'd200, 1'b0},
        {8'd200, 1'b0}, {8'd200, 1'b0}, {8'd200, 1'b0}, {8'd200, 1'b0},
        {8'd200, 1'b1}, {8'd200, 1'b1}, {8'd200, 1'b1}, {8'd200, 1'b0},
        {8'd0,   1'b0}, {8'd0,   1'b0}, {8'd0,   1'b1}
    };

    cvsd_encoder #(
        .BASE_DIV (DIV),
        .STEP_INC (INC),
        .STEP_MAX (SMAX)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .pcm_in   (pcm_in),
        .bit_stb  (bit_stb),
        .bit_out  (bit_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ref  = 128;
        m_step = 1;
        m_hist = 3'b000;
    endtask

    // one bit period: present sample, wait for the strobe, step the model
    task automatic push(input logic [7:0] s, output int exp_bit);
        logic d;
        pcm_in = s;
        do @(negedge clk); while (!bit_stb);
        @(negedge clk);
        d = (m_ref < int'(s)) ? 1'b0 : 1'b1;
        m_hist = {m_hist[1:0], d};
        if (m_hist == 3'b000 || m_hist == 3'b111)
            m_step = (m_step + INC > SMAX) ? SMAX : m_step + INC;
        else
            m_step = 1;
        if (d) m_ref = (m_ref - m_step < 0) ? 0 : m_ref - m_step;
        else   m_ref = (m_ref + m_step > 255) ? 255 : m_ref + m_step;
        exp_bit = int'(m_hist[2]);
    endtask

    task automatic push_chk(input string tag, input logic [7:0] s);
        int e;
        push(s, e);
        check(tag, int'(bit_out), e);
    endtask

    task automatic measure_period(input logic [1:0] rs, input int exp);
        int n;
        rate_sel = rs;
        do @(negedge clk); while (!bit_stb);
        do @(negedge clk); while (!bit_stb);
        n = 0;
        do begin @(negedge clk); n++; end while (!bit_stb);
        check("R2 strobe period", n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 bit_out in reset", int'(bit_out), 0);
        check("R1 bit_stb in reset", int'(bit_stb), 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R7: hand-worked table from reset
        foreach (VEC[i]) begin
            push(VEC[i][8:1], e);
            check("R5/R6 table bit", int'(bit_out), int'(VEC[i][0]));
        end

        // R4: output steady between strobes
        @(negedge clk);
        e = int'(bit_out);
        @(negedge clk);
        check("R4 hold between strobes", int'(bit_out), e);

        // R1: mid-stream reset restores 128 / step 1 / empty history
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 bit_out after reset", int'(bit_out), 0);
        check("R1 bit_stb after reset", int'(bit_stb), 0);
        rst_n = 1'b1;
        model_reset();
        // R9 R3: around mid-scale the decisions alternate on the stored level
        for (int k = 0; k < 8; k++) push_chk("R9 mid-scale", (k % 2 == 0) ? 8'd128 : 8'd129);

        // R5 R8: drive into the bottom rail, then step off by one code
        for (int k = 0; k < 40; k++) push_chk("R8 low rail", 8'd0);
        for (int k = 0; k < 6; k++) push_chk("R8 low exit", 8'd1);
        // R5 R8: drive into the top rail, then step off by one code
        for (int k = 0; k < 40; k++) push_chk("R8 high rail", 8'd255);
        for (int k = 0; k < 6; k++) push_chk("R8 high exit", 8'd254);
        // R6 R7: slow ramp tracked with minimum steps
        for (int k = 0; k < 30; k++) push_chk("R7 ramp", 8'(100 + k));

        // R2: strobe spacing per rate code
        measure_period(2'd0, DIV);
        measure_period(2'd1, 2 * DIV);
        measure_period(2'd2, 4 * DIV);
        measure_period(2'd3, 4 * DIV);
        rate_sel = 2'd0;
        // R2: strobe is a single-cycle pulse
        do @(negedge clk); while (!bit_stb);
        @(negedge clk);
        check("R2 pulse width", int'(bit_stb), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule